// File: doc/BRIEF.md
# Sequential Radix-4 Booth Multiplier with Truncating Mode

This block multiplies two signed two's-complement operands of `W` bits and handles one radix-4 Booth digit on each clock. A pulse on `start` while the block is idle latches the multiplicand, the multiplier and the mode. `busy` is high while digits are being processed. A one-cycle `done` pulse marks the point where the 2W-bit signed `product` becomes valid. The product then holds its value until the next operation completes.

Each digit is recoded from a 3-bit window of the multiplier into three controls: negate, double and non-zero. These controls choose 0, X or 2X and make the step either an add or a subtract. The result lands in the upper part of a running partial product. The partial product then moves two places to the right by an arithmetic shift, and the bits that fall out collect in a lower register.

In exact mode the multiplier is extended by a zero below its LSB, and all W/2 digits are processed. In truncating mode the least significant digit is skipped, so one cycle is saved and the first window is multiplier bits [3:1]. The result is then realigned so that it has the same weight as an exact product.

Top module: `booth_r4_seq_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is 0.
- R2: With `approx` = 0 at start, `product` equals the exact signed product of `mcand` and `mplier` for every operand pair, including -2^(W-1) in either or both positions.
- R3: With `approx` = 1 at start, `product` equals the sum over i = 1 .. W/2-1 of d_i·X·4^i. Here d_i is the Booth digit of multiplier bits [2i+1 : 2i-1] (bit -1 taken as 0), and bits [1:0] of `product` are 0.
- R4: Each window (b2 b1 b0) recodes to the digit -2·b2 + b1 + b0. That gives 000→0, 001→+1, 010→+1, 011→+2, 100→-2, 101→-1, 110→-1 and 111→0, and it holds for every digit position.
- R5: `done` rises W/2 clock edges after the edge that accepts `start` in exact mode, and W/2-1 edges after it in truncating mode.
- R6: `done` is high for exactly one cycle. `busy` is high from the edge after acceptance until the edge that raises `done`, and it is never high together with `done`.
- R7: `start` is ignored while `busy` is high. Changes to `mcand`, `mplier` or `approx` after acceptance do not affect the running result.
- R8: `product` keeps its value from the cycle of `done` until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiply; accepted only while idle |
| approx | input | 1 | 1 = skip the lowest Booth digit, 0 = exact |
| mcand | input | W | Signed multiplicand X |
| mplier | input | W | Signed multiplier Y |
| busy | output | 1 | Digits in progress |
| done | output | 1 | One-cycle pulse, `product` valid |
| product | output | 2W | Signed product |

## Verification
The bench builds the block with the default W = 8. At that width a short loop can sweep every multiplier value against fixed multiplicands, which places every window code in every digit position in both modes. The most-negative operand corners are reachable directly. Thousands of random pairs per mode cover the operand space. Eight bits also keep the latency small enough for the bench to count edges from acceptance to `done` exactly, and to inject a second `start` together with new operands in the middle of a run.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

    // Controls derived from one radix-4 window
    typedef struct packed {
        logic neg;   // subtract the multiple
        logic two;   // use 2X instead of X
        logic non0;  // multiple is non-zero
    } booth_ctl_t;

endpackage

// File: rtl/booth_digit_recoder.sv
module booth_digit_recoder
    import booth_mul_pkg::*;
(
    input  logic [2:0]  grp,
    output booth_ctl_t  ctl
);
    always_comb begin
        ctl.non0 = !((grp == 3'b000) || (grp == 3'b111));
        ctl.two  = (grp == 3'b011) || (grp == 3'b100);
        ctl.neg  = grp[2] && ctl.non0;
    end
endmodule

// File: rtl/booth_multiple_sel.sv
module booth_multiple_sel
    import booth_mul_pkg::*;
#(
    parameter int W = 8,
    localparam int AW = W + 2
) (
    input  logic [W-1:0]  x,
    input  booth_ctl_t    ctl,
    output logic [AW-1:0] mult
);
    logic signed [AW-1:0] x_ext;

    always_comb begin
        x_ext = AW'($signed(x));
        if (!ctl.non0)
            mult = '0;
        else if (ctl.two)
            mult = x_ext <<< 1;
        else
            mult = x_ext;
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub #(
    parameter int AW = 10
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic          sub,
    output logic [AW-1:0] y
);
    always_comb begin
        y = sub ? (a - b) : (a + b);
    end
endmodule

// File: rtl/booth_r4_seq_mul.sv
module booth_r4_seq_mul
    import booth_mul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           approx,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    localparam int AW  = W + 2;            // running partial product width
    localparam int YW  = W + 1;            // multiplier with appended bit
    localparam int DIG = W / 2;            // digits in exact mode
    localparam int CW  = $clog2(DIG + 1);
    localparam int PW  = 2 * W;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          trunc;
        logic [CW-1:0] cnt;
        logic [W-1:0]  x;
        logic [YW-1:0] ysh;
        logic [AW-1:0] acc;
        logic [W-1:0]  low;
        logic [PW-1:0] prod;
    } mul_state_t;

    mul_state_t st_q, st_d;

    booth_ctl_t    ctl;
    logic [AW-1:0] mult;
    logic [AW-1:0] sum;

    booth_digit_recoder u_rec (
        .grp (st_q.ysh[2:0]),
        .ctl (ctl)
    );

    booth_multiple_sel #(.W(W)) u_sel (
        .x    (st_q.x),
        .ctl  (ctl),
        .mult (mult)
    );

    booth_addsub #(.AW(AW)) u_add (
        .a   (st_q.acc),
        .b   (mult),
        .sub (ctl.neg),
        .y   (sum)
    );

    logic signed [YW-1:0] y_app;
    logic signed [YW-1:0] y_load;

    always_comb begin
        y_app  = {mplier, 1'b0};
        y_load = approx ? (y_app >>> 2) : y_app;

        st_d      = st_q;
        st_d.done = 1'b0;

        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.trunc = approx;
                st_d.x     = mcand;
                st_d.ysh   = y_load;
                st_d.acc   = '0;
                st_d.low   = '0;
                st_d.cnt   = approx ? CW'(DIG - 1) : CW'(DIG);
            end
        end else begin
            st_d.acc = AW'($signed(sum) >>> 2);
            st_d.low = {sum[1:0], st_q.low[W-1:2]};
            st_d.ysh = YW'($signed(st_q.ysh) >>> 2);
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                if (st_q.trunc)
                    st_d.prod = {st_d.acc[W-1:0], st_d.low[W-1:2], 2'b00};
                else
                    st_d.prod = {st_d.acc[W-1:0], st_d.low};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign product = st_q.prod;

endmodule

// File: rtl/booth_r4_seq_mul_chk.sv
module booth_r4_seq_mul_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           approx,
    input logic           busy,
    input logic           done,
    input logic [2*W-1:0] product
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] run_cnt;
    logic          lat_trunc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt   <= '0;
            lat_trunc <= 1'b0;
        end else if (start && !busy) begin
            run_cnt   <= '0;
            lat_trunc <= approx;
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R6: done lasts one cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: busy and done never overlap
    a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R5: accepted start leads to busy on the next edge
    a_r5_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R5: cycle count to done matches the latched mode
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == (lat_trunc ? CW'(W/2 - 1) : CW'(W/2))));

    // R8: product only moves on completion
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(product));

endmodule

bind booth_r4_seq_mul booth_r4_seq_mul_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .approx  (approx),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/booth_r4_seq_mul_test.sv
module booth_r4_seq_mul_test;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           approx = 1'b0;
    logic [W-1:0]   mcand = '0;
    logic [W-1:0]   mplier = '0;
    logic           busy;
    logic           done;
    logic [2*W-1:0] product;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    booth_r4_seq_mul #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .approx(approx),
        .mcand(mcand), .mplier(mplier), .busy(busy), .done(done),
        .product(product)
    );

    function automatic logic [15:0] ref_exact(input logic [7:0] x, input logic [7:0] y);
        int p;
        p = $signed(x) * $signed(y);
        return p[15:0];
    endfunction

    function automatic logic [15:0] ref_trunc(input logic [7:0] x, input logic [7:0] y);
        logic [8:0] ye;
        int acc;
        int d;
        ye  = {y, 1'b0};
        acc = 0;
        for (int i = 1; i < 4; i++) begin
            d = -2 * int'(ye[2*i+2]) + int'(ye[2*i+1]) + int'(ye[2*i]);
            acc += d * int'($signed(x)) * (4 ** i);
        end
        return acc[15:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Runs one multiply; optionally disturbs inputs and start mid-run (R7)
    task automatic run_op(input logic [7:0] x, input logic [7:0] y, input bit md,
                          input bit disturb, input string req);
        int lat;
        logic [15:0] exp;
        exp = md ? ref_trunc(x, y) : ref_exact(x, y);
        @(negedge clk);
        mcand = x; mplier = y; approx = md; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        lat = 0;
        if (disturb) begin
            mcand = ~x; mplier = y ^ 8'h5A; approx = ~md; start = 1'b1;
        end
        while (!done && lat < 50) begin
            @(posedge clk); #1;
            lat++;
            start = 1'b0;
        end
        check(lat == (md ? 3 : 4), "R5", "latency", lat, md ? 3 : 4);
        check(product == exp, req, "product", product, exp);
        if (md) check(product[1:0] == 2'b00, "R3", "low bits", product[1:0], 0);
        @(posedge clk); #1;
        check(!done, "R6", "done pulse length", done, 0);
    endtask

    initial begin
        #900000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog timeout actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx, ry;
        logic [15:0] held;
        void'($urandom(32'h1234_5678));
        #12;
        check(!busy && !done && product == 0, "R1", "reset state",
              {busy, done, product}, 0);
        @(negedge clk); rst_n = 1'b1;

        // Most-negative corners, exact (R2)
        run_op(8'h80, 8'h80, 0, 0, "R2");
        run_op(8'h80, 8'h7F, 0, 0, "R2");
        run_op(8'h7F, 8'h80, 0, 0, "R2");
        run_op(8'hFF, 8'hFF, 0, 0, "R2");
        run_op(8'h00, 8'h80, 0, 0, "R2");
        run_op(8'h80, 8'h80, 1, 0, "R3");
        run_op(8'h7F, 8'h80, 1, 0, "R3");

        // Every window code in every digit position (R4)
        for (int y = 0; y < 256; y++) run_op(8'h03, y[7:0], 0, 0, "R4");
        for (int y = 0; y < 256; y++) run_op(8'h80, y[7:0], 1, 0, "R4");

        // Start and operand changes mid-run are ignored (R7)
        run_op(8'h35, 8'hC3, 0, 1, "R7");
        run_op(8'hA1, 8'h6E, 1, 1, "R7");

        // Product holds while idle (R8)
        held = product;
        repeat (5) @(posedge clk);
        #1;
        check(product == held && !busy, "R8", "idle hold", product, held);

        // Random pairs in both modes (R2, R3)
        for (int k = 0; k < 6000; k++) begin
            rx = 8'($urandom); ry = 8'($urandom);
            run_op(rx, ry, 0, (k % 97) == 0, "R2");
        end
        for (int k = 0; k < 6000; k++) begin
            rx = 8'($urandom); ry = 8'($urandom);
            run_op(rx, ry, 1, (k % 89) == 0, "R3");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule